// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block is the control state machine of a network clock synchronizer running in automatic mode. It watches a loss flag for the primary reference, a loss flag for the secondary reference and a guard-time-elapsed flag. From these it decides each clock whether the downstream loop locks to the primary, locks to the secondary, holds its last frequency, or free-runs.

When the primary fails and the secondary is still present, the block does not switch straight away. It first parks in an auto-holdover state for the reference it was tracking. It switches only once an external guard timer reports that the loss has lasted long enough.

Each state change is also classified by how the loop must treat phase, and the class is reported:
- Leaving free-run re-aligns phase.
- Returning from any holdover to a locked state requires the phase-error (TIE) corrector, which gets a one-cycle enable pulse.
- Every other change keeps phase continuity without the corrector.

Automatic operation applies only while the mode pins read 11 and the manual select pin is low. Otherwise the machine freezes.

Top module: `refsel_ctrl`

## Requirements
- R1: While rst_ni is low, the outputs are held at their reset values: state_o=0 (free-run), ref_sel_o=0, holdover_o=0, tie_en_o=0 and xfer_o=0. The reset is asynchronous.
- R2: state_o uses this encoding: 0 free-run, 1 locked-primary, 2 locked-secondary, 3 holdover-primary, 4 holdover-secondary, 5 auto-holdover-primary, 6 auto-holdover-secondary. Inputs sampled at a rising edge are reflected in the outputs right after that edge.
- R3: With los_pri_i low, the next state is locked-primary from every state.
- R4: With los_pri_i high and los_sec_i low:
  - locked-primary moves to auto-holdover-primary.
  - Either auto-holdover state stays put while guard_i is low, and moves to locked-secondary when guard_i is high.
  - locked-secondary stays.
- R5: With both loss flags high:
  - locked-primary and auto-holdover-primary move to holdover-primary.
  - locked-secondary and auto-holdover-secondary move to holdover-secondary.
  - The holdover states and free-run stay.
- R6: With only the secondary present:
  - holdover-primary moves to auto-holdover-secondary.
  - holdover-secondary moves to locked-secondary.
  - free-run moves to locked-secondary.
- R7: ref_sel_o is 0 in the three primary-side states and 1 in the three secondary-side states. It keeps its value while in free-run. holdover_o is 1 exactly in the four holdover and auto-holdover states.
- R8: tie_en_o pulses high for one cycle after each edge where a holdover or auto-holdover state moves to a locked state.
- R9: xfer_o classifies the change taken at the last edge: 0 no change, 1 phase re-align (left free-run), 2 continuity without corrector, 3 continuity with corrector.
- R10: Automatic operation requires mode_i=2'b11 and man_sel_i=0. Otherwise the state and ref_sel_o are frozen, and tie_en_o and xfer_o read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode pins; 11 selects automatic |
| man_sel_i | input | 1 | Manual reference select; must be 0 for automatic |
| los_pri_i | input | 1 | Primary reference lost |
| los_sec_i | input | 1 | Secondary reference lost |
| guard_i | input | 1 | Guard time elapsed |
| state_o | output | 3 | Current state code |
| ref_sel_o | output | 1 | Active reference: 0 primary, 1 secondary |
| holdover_o | output | 1 | Loop in holdover |
| tie_en_o | output | 1 | One-cycle TIE corrector enable |
| xfer_o | output | 2 | Phase treatment of the last transition |

## Verification
Every register sits directly behind a port, so a wrong next-state choice shows on state_o one edge after the offending inputs were sampled. The same wrong choice usually also shows on ref_sel_o, holdover_o or xfer_o in that same cycle.

A misclassified transition is a subtler fault. It is visible only in the single cycle after the edge, as a missing or extra tie_en_o pulse or a wrong xfer_o code. The vectors therefore reach every holdover-to-locked exit and compare those outputs on each step.

A broken freeze gate would show as a state change on the first edge with the mode pins off automatic.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int ST_W = 3;
  localparam int XF_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FREE  = 3'd0,
    ST_NRM_P = 3'd1,
    ST_NRM_S = 3'd2,
    ST_HO_P  = 3'd3,
    ST_HO_S  = 3'd4,
    ST_AHO_P = 3'd5,
    ST_AHO_S = 3'd6
  } st_e;

  typedef enum logic [XF_W-1:0] {
    XF_NONE  = 2'd0,
    XF_ALIGN = 2'd1,
    XF_PLAIN = 2'd2,
    XF_TIE   = 2'd3
  } xf_e;

  function automatic logic is_locked(st_e s);
    return (s == ST_NRM_P) || (s == ST_NRM_S);
  endfunction

  function automatic logic is_hold(st_e s);
    return (s == ST_HO_P) || (s == ST_HO_S) || (s == ST_AHO_P) || (s == ST_AHO_S);
  endfunction

  function automatic logic is_sec(st_e s);
    return (s == ST_NRM_S) || (s == ST_HO_S) || (s == ST_AHO_S);
  endfunction

endpackage

// File: rtl/refsel_next.sv
module refsel_next
  import refsel_pkg::*;
(
  input  st_e  cur_i,
  input  logic los_pri_i,
  input  logic los_sec_i,
  input  logic guard_i,
  output st_e  nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    if (!los_pri_i) begin
      nxt_o = ST_NRM_P;
    end else if (!los_sec_i) begin
      unique case (cur_i)
        ST_FREE:            nxt_o = ST_NRM_S;
        ST_NRM_P:           nxt_o = ST_AHO_P;
        ST_AHO_P, ST_AHO_S: nxt_o = guard_i ? ST_NRM_S : cur_i;
        ST_HO_P:            nxt_o = ST_AHO_S;
        ST_HO_S:            nxt_o = ST_NRM_S;
        ST_NRM_S:           nxt_o = ST_NRM_S;
        default:            nxt_o = ST_FREE;
      endcase
    end else begin
      unique case (cur_i)
        ST_NRM_P, ST_AHO_P: nxt_o = ST_HO_P;
        ST_NRM_S, ST_AHO_S: nxt_o = ST_HO_S;
        ST_FREE, ST_HO_P, ST_HO_S: nxt_o = cur_i;
        default:            nxt_o = ST_FREE;
      endcase
    end
  end

endmodule

// File: rtl/refsel_xfer.sv
module refsel_xfer
  import refsel_pkg::*;
(
  input  st_e cur_i,
  input  st_e nxt_i,
  output xf_e cls_o
);

  always_comb begin
    if (cur_i == nxt_i)                         cls_o = XF_NONE;
    else if (cur_i == ST_FREE)                  cls_o = XF_ALIGN;
    else if (is_hold(cur_i) && is_locked(nxt_i)) cls_o = XF_TIE;
    else                                        cls_o = XF_PLAIN;
  end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int          MODE_W    = 2,
  parameter logic [MODE_W-1:0] AUTO_MODE = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              man_sel_i,
  input  logic              los_pri_i,
  input  logic              los_sec_i,
  input  logic              guard_i,
  output logic [ST_W-1:0]   state_o,
  output logic              ref_sel_o,
  output logic              holdover_o,
  output logic              tie_en_o,
  output logic [XF_W-1:0]   xfer_o
);

  st_e  state_q, state_d;
  xf_e  xf_q, cls;
  logic ref_q, tie_q;
  logic auto_en;

  assign auto_en = (mode_i == AUTO_MODE) && !man_sel_i;

  refsel_next u_next (
    .cur_i     (state_q),
    .los_pri_i (los_pri_i),
    .los_sec_i (los_sec_i),
    .guard_i   (guard_i),
    .nxt_o     (state_d)
  );

  refsel_xfer u_xfer (
    .cur_i (state_q),
    .nxt_i (state_d),
    .cls_o (cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      ref_q   <= 1'b0;
      xf_q    <= XF_NONE;
      tie_q   <= 1'b0;
    end else if (auto_en) begin
      state_q <= state_d;
      xf_q    <= cls;
      tie_q   <= (cls == XF_TIE);
      if (state_d != ST_FREE) ref_q <= is_sec(state_d);
    end else begin
      xf_q    <= XF_NONE;
      tie_q   <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign ref_sel_o  = ref_q;
  assign holdover_o = is_hold(state_q);
  assign tie_en_o   = tie_q;
  assign xfer_o     = xf_q;

  assert_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en |=> ($stable(state_o) && $stable(ref_sel_o) && !tie_en_o));

  assert_tie_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_en_o |=> !tie_en_o);

  assert_pri_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_NRM_P && $past(state_o) != ST_NRM_P) |-> !$past(los_pri_i));

  assert_sec_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_NRM_S && $past(state_o) != ST_NRM_S) |-> !$past(los_sec_i));

  assert_guard_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_NRM_S && ($past(state_o) == ST_AHO_P || $past(state_o) == ST_AHO_S))
      |-> $past(guard_i));

  assert_free_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_FREE && state_o != ST_FREE) |-> (xfer_o == XF_ALIGN));

  assert_free_ref_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FREE) |=> (state_o != ST_FREE || $stable(ref_sel_o)));

endmodule

// File: tb/refsel_ctrl_test.sv
module refsel_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       msel = 1'b0;
  logic       lp = 1'b1, ls = 1'b1, gt = 1'b0;
  logic [2:0] st;
  logic       rs, ho, tie;
  logic [1:0] xf;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  refsel_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .man_sel_i(msel),
    .los_pri_i(lp), .los_sec_i(ls), .guard_i(gt),
    .state_o(st), .ref_sel_o(rs), .holdover_o(ho), .tie_en_o(tie), .xfer_o(xf)
  );

  // {mode, man_sel, los_sec, los_pri, guard, state, ref, hold, tie, xfer}
  localparam int NV = 31;
  localparam logic [13:0] VEC [NV] = '{
    {2'b11, 1'b0, 3'b110, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b000, 3'd1, 1'b0, 1'b0, 1'b0, 2'd1},
    {2'b11, 1'b0, 3'b000, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b010, 3'd5, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b010, 3'd5, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b011, 3'd2, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 3'b011, 3'd2, 1'b1, 1'b0, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b110, 3'd4, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b111, 3'd4, 1'b1, 1'b1, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b010, 3'd2, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 3'b001, 3'd1, 1'b0, 1'b0, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b010, 3'd5, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b001, 3'd1, 1'b0, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 3'b010, 3'd5, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b110, 3'd3, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b111, 3'd3, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b010, 3'd6, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b010, 3'd6, 1'b1, 1'b1, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b011, 3'd2, 1'b1, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 3'b110, 3'd4, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b000, 3'd1, 1'b0, 1'b0, 1'b1, 2'd3},
    {2'b10, 1'b0, 3'b010, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'b11, 1'b1, 3'b110, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'b11, 1'b0, 3'b110, 3'd3, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b011, 3'd6, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b101, 3'd1, 1'b0, 1'b0, 1'b1, 2'd3},
    {2'b11, 1'b0, 3'b010, 3'd5, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b110, 3'd3, 1'b0, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b010, 3'd6, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b11, 1'b0, 3'b110, 3'd4, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'b01, 1'b0, 3'b000, 3'd4, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_st, input int e_rs,
                         input int e_ho, input int e_tie, input int e_xf);
    chk({tag, " state R2"}, int'(st), e_st);
    chk({tag, " ref_sel R7"}, int'(rs), e_rs);
    chk({tag, " holdover R7"}, int'(ho), e_ho);
    chk({tag, " tie R8"}, int'(tie), e_tie);
    chk({tag, " xfer R9"}, int'(xf), e_xf);
  endtask

  task automatic step(input logic [1:0] m, input logic s, input logic [2:0] v);
    mode = m; msel = s; {ls, lp, gt} = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("reset R1", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R10 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13:12], VEC[i][11], VEC[i][10:8]);
      chk_all($sformatf("vec %0d R3/R4/R5/R6/R10", i), int'(VEC[i][7:5]),
              int'(VEC[i][4]), int'(VEC[i][3]), int'(VEC[i][2]), int'(VEC[i][1:0]));
    end

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk_all("async reset R1", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 R7 free-run holds with both lost
    step(2'b11, 1'b0, 3'b111);
    chk_all("free hold R5", 0, 0, 0, 0, 0);

    // R6 free-run to secondary without waiting for guard
    step(2'b11, 1'b0, 3'b010);
    chk_all("free to sec R6", 2, 1, 0, 0, 1);

    // R4 secondary stays while primary still lost
    step(2'b11, 1'b0, 3'b010);
    chk_all("sec stays R4", 2, 1, 0, 0, 0);

    // R10 man_sel freeze blocks revert to primary
    step(2'b11, 1'b1, 3'b000);
    chk_all("man_sel freeze R10", 2, 1, 0, 0, 0);

    // R3 revert on return to auto
    step(2'b11, 1'b0, 3'b100);
    chk_all("revert R3", 1, 0, 0, 0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule